// File: doc/BRIEF.md
# Interrupt Gate with Mask, Force and Pending Registers

This block is the front end of a 64-line interrupt controller. Raw interrupt lines pass through a two-stage synchronizer. The synchronized lines are then combined with a 64-bit mask and a 64-bit software force vector to produce one qualified request per source, plus a single flag that is set when any request is active. A small synchronous register bus gives software access to the mask and force words. It also gives a read-only view of the synchronized lines, the "pending" bits.

Each 64-bit quantity is held as two 32-bit words. The high word covers sources 63 to 32 and the low word covers sources 31 to 0. Bit 0 of the low mask word is not a mask bit. Writing 1 there sets every mask bit in a single write. This global blocking action also makes source 0 a software-only source: its raw line has no effect, and only force bit 0 can drive its request.

A request set through the force word always reaches the output, whatever the mask holds. Software can therefore schedule an interrupt for itself on any source. Priority, encoding, vectoring and acknowledge are handled downstream.

Top module: `irq_gate_regs`

## Requirements
- R1: After reset, every mask bit is 1, so the mask high word reads 0xFFFFFFFF and the mask low word reads 0xFFFFFFFE. Both force words read 0, and all requests and the any flag are 0.
- R2: For sources 63 to 1, a mask bit of 1 blocks the source's synchronized raw line and a mask bit of 0 passes it to the request output.
- R3: Writing the mask low word (offset 0xC) with bit 0 set drives all 63 mask bits to 1, whatever the other data bits and the previous mask. Bit 0 of the mask low word always reads 0.
- R4: After a global mask write, individual mask bits can be written back to 0 through offset 0x8 or 0xC, which unmasks exactly those sources.
- R5: A force bit of 1 asserts the request for its source even when that source's mask bit is 1. Writing the force bit to 0 withdraws the request.
- R6: The pending words show each synchronized raw line whether or not the source is masked. Pending bit 0 always reads 0.
- R7: The raw line of source 0 is ignored. Request bit 0 equals force bit 0.
- R8: The any-request output is 1 exactly when at least one bit of the request vector is 1.
- R9: The register byte offsets are 0x0 pending high, 0x4 pending low, 0x8 mask high, 0xC mask low, 0x10 force high and 0x14 force low. Writes to the pending offsets change nothing. Reads of any other offset, including offsets that are not word aligned, return 0.
- R10: A change on a raw line shows up in the pending and request outputs after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read access |
| irq_raw_i | input | 64 | Asynchronous raw interrupt lines |
| irq_req_o | output | 64 | Qualified request per source |
| irq_any_o | output | 1 | OR of all qualified requests |

## Verification
The directed patterns are chosen so that each one isolates a single path into the request output. All raw lines high under the reset mask shows that masking blocks every source while pending still reports them. A fully cleared mask then shows that source 0 stays silent. A global mask write with zero data bits shows that the mask-all bit acts on its own. Single force bits at the two ends of the vector, applied under a full mask, show that the force path bypasses the mask. A raw toggle sampled one edge and then two edges later separates a correct synchronizer depth from one that is too short or too long. Random mask, force and raw words, with an occasional mask-all write, mix all three paths so that a wrong combination of them, such as AND in place of OR, shows up.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  localparam int BUS_ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_PEND_HI,
    SEL_PEND_LO,
    SEL_MASK_HI,
    SEL_MASK_LO,
    SEL_FRC_HI,
    SEL_FRC_LO,
    SEL_NONE
  } reg_sel_e;

  // byte offset -> register; misaligned or unmapped offsets select nothing
  function automatic reg_sel_e decode_offset(input logic [BUS_ADDR_W-1:0] addr);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr[BUS_ADDR_W-1:2])
        3'd0: sel = SEL_PEND_HI;
        3'd1: sel = SEL_PEND_LO;
        3'd2: sel = SEL_MASK_HI;
        3'd3: sel = SEL_MASK_LO;
        3'd4: sel = SEL_FRC_HI;
        3'd5: sel = SEL_FRC_LO;
        default: sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             warm_o
);
  localparam int CNT_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // counts edges since reset so that checks on history know when it is valid
  logic [CNT_W-1:0] warm_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              warm_cnt_q <= '0;
    else if (warm_cnt_q != CNT_W'(STAGES))    warm_cnt_q <= warm_cnt_q + 1'b1;
  end
  assign warm_o = (warm_cnt_q == CNT_W'(STAGES));

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_gate_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_en_i,
  input  logic                  bus_we_i,
  input  logic [BUS_ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0]     bus_wdata_i,
  output logic [WORD_W-1:0]     bus_rdata_o,
  input  logic [2*WORD_W-1:0]   sync_i,
  output logic [2*WORD_W-1:0]   mask_o,
  output logic [2*WORD_W-1:0]   force_o,
  output logic                  mask_all_evt_o,
  output logic                  pend_wr_evt_o
);
  localparam int NSRC = 2 * WORD_W;

  reg_sel_e          sel;
  logic              wr_evt;
  logic              rd_evt;
  logic [NSRC-1:1]   mask_q;
  logic [NSRC-1:0]   force_q;
  logic [NSRC-1:0]   pend_vec;
  logic [NSRC-1:0]   mask_vec;

  assign sel            = decode_offset(bus_addr_i);
  assign wr_evt         = bus_en_i &&  bus_we_i;
  assign rd_evt         = bus_en_i && !bus_we_i;
  assign mask_all_evt_o = wr_evt && (sel == SEL_MASK_LO) && bus_wdata_i[0];
  assign pend_wr_evt_o  = wr_evt && ((sel == SEL_PEND_HI) || (sel == SEL_PEND_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      force_q <= '0;
    end else if (wr_evt) begin
      case (sel)
        SEL_MASK_HI: mask_q[NSRC-1:WORD_W] <= bus_wdata_i;
        SEL_MASK_LO: begin
          if (bus_wdata_i[0]) mask_q <= '1;
          else                mask_q[WORD_W-1:1] <= bus_wdata_i[WORD_W-1:1];
        end
        SEL_FRC_HI:  force_q[NSRC-1:WORD_W] <= bus_wdata_i;
        SEL_FRC_LO:  force_q[WORD_W-1:0]    <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign pend_vec = {sync_i[NSRC-1:1], 1'b0};
  assign mask_vec = {mask_q, 1'b0};
  assign mask_o   = mask_vec;
  assign force_o  = force_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_evt) begin
      case (sel)
        SEL_PEND_HI: bus_rdata_o = pend_vec[NSRC-1:WORD_W];
        SEL_PEND_LO: bus_rdata_o = pend_vec[WORD_W-1:0];
        SEL_MASK_HI: bus_rdata_o = mask_vec[NSRC-1:WORD_W];
        SEL_MASK_LO: bus_rdata_o = mask_vec[WORD_W-1:0];
        SEL_FRC_HI:  bus_rdata_o = force_q[NSRC-1:WORD_W];
        SEL_FRC_LO:  bus_rdata_o = force_q[WORD_W-1:0];
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assert_maskall_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_all_evt_o |=> (&mask_q));

  assert_pend_write_inert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr_evt_o |=> ($stable(mask_q) && $stable(force_q)));

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && (sel == SEL_NONE)) |-> (bus_rdata_o == '0));

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NSRC = 64
) (
  input  logic [NSRC-1:0] sync_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] force_i,
  output logic [NSRC-1:0] req_o,
  output logic            any_o
);
  // source 0 is software-only: its raw line never contributes
  function automatic logic [NSRC-1:0] qualify_vec(
    input logic [NSRC-1:0] s,
    input logic [NSRC-1:0] m,
    input logic [NSRC-1:0] f
  );
    logic [NSRC-1:0] q;
    q[0] = f[0];
    for (int i = 1; i < NSRC; i++) q[i] = (s[i] & ~m[i]) | f[i];
    return q;
  endfunction

  assign req_o = qualify_vec(sync_i, mask_i, force_i);
  assign any_o = |req_o;

endmodule

// File: rtl/irq_gate_regs.sv
module irq_gate_regs
  import irq_gate_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_en_i,
  input  logic                  bus_we_i,
  input  logic [BUS_ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0]     bus_wdata_i,
  output logic [WORD_W-1:0]     bus_rdata_o,
  input  logic [2*WORD_W-1:0]   irq_raw_i,
  output logic [2*WORD_W-1:0]   irq_req_o,
  output logic                  irq_any_o
);
  localparam int NSRC        = 2 * WORD_W;
  localparam int SYNC_STAGES = 2;

  logic [NSRC-1:0] sync_vec;
  logic [NSRC-1:0] mask_vec;
  logic [NSRC-1:0] force_vec;
  logic            sync_warm;
  logic            mask_all_evt;
  logic            pend_wr_evt;

  irq_src_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_raw_i),
    .sync_o (sync_vec),
    .warm_o (sync_warm)
  );

  irq_reg_file #(.WORD_W(WORD_W)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bus_en_i       (bus_en_i),
    .bus_we_i       (bus_we_i),
    .bus_addr_i     (bus_addr_i),
    .bus_wdata_i    (bus_wdata_i),
    .bus_rdata_o    (bus_rdata_o),
    .sync_i         (sync_vec),
    .mask_o         (mask_vec),
    .force_o        (force_vec),
    .mask_all_evt_o (mask_all_evt),
    .pend_wr_evt_o  (pend_wr_evt)
  );

  irq_qualify #(.NSRC(NSRC)) u_qual (
    .sync_i  (sync_vec),
    .mask_i  (mask_vec),
    .force_i (force_vec),
    .req_o   (irq_req_o),
    .any_o   (irq_any_o)
  );

  assert_force_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((force_vec & ~irq_req_o) == '0));

  assert_mask_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_req_o & ~force_vec & mask_vec & ~NSRC'(1)) == '0));

  assert_src0_force_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o[0] == force_vec[0]));

  assert_any_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_any_o == (irq_req_o != '0)));

  assert_sync_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_warm |-> (sync_vec == $past(irq_raw_i, 2)));

endmodule

// File: tb/irq_gate_regs_tb_top.sv
`timescale 1ns/1ps
module irq_gate_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] raw = '0;
  logic [63:0] req;
  logic        any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_mask;
  logic [63:0] m_force;

  always #2.5 clk = ~clk;

  irq_gate_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_raw_i(raw), .irq_req_o(req), .irq_any_o(any)
  );

  function automatic logic [63:0] exp_req(input logic [63:0] r, input logic [63:0] m,
                                          input logic [63:0] f);
    logic [63:0] pass;
    pass = r & ~m;
    pass[0] = 1'b0;
    return pass | f;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic set_raw_settle(input logic [63:0] v);
    @(negedge clk);
    raw = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // model of a mask write; mask-all leaves every bit but 0 set
  task automatic model_mask(input bit hi, input logic [31:0] d);
    if (hi) m_mask[63:32] = d;
    else if (d[0]) m_mask = 64'hFFFF_FFFF_FFFF_FFFE;
    else m_mask[31:0] = {d[31:1], 1'b0};
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_mask = 64'hFFFF_FFFF_FFFF_FFFE;
    m_force = '0;

    // R1 reset state
    rd(5'h08, d); chk("R1 mask hi", {32'd0, d}, 64'hFFFF_FFFF);
    rd(5'h0C, d); chk("R1 mask lo", {32'd0, d}, 64'hFFFF_FFFE);
    rd(5'h10, d); chk("R1 force hi", {32'd0, d}, 64'd0);
    rd(5'h14, d); chk("R1 force lo", {32'd0, d}, 64'd0);
    chk("R1 req", req, 64'd0);
    chk("R1 any", {63'd0, any}, 64'd0);

    // R6 pending visible while masked, R2 masked blocks
    set_raw_settle('1);
    rd(5'h00, d); chk("R6 pend hi masked", {32'd0, d}, 64'hFFFF_FFFF);
    rd(5'h04, d); chk("R6 pend lo bit0 zero", {32'd0, d}, 64'hFFFF_FFFE);
    chk("R2 all masked req", req, 64'd0);

    // R2 unmask all, R7 source 0 ignored, R8 any
    wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
    m_mask = '0;
    @(negedge clk);
    chk("R2 R7 unmasked req", req, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R8 any set", {63'd0, any}, 64'd1);

    // R10 latency: one edge unchanged, second edge changed
    @(negedge clk) raw = 64'h0000_0000_0000_0101;
    @(posedge clk); @(negedge clk);
    chk("R10 after one edge", req, 64'hFFFF_FFFF_FFFF_FFFE);
    @(posedge clk); @(negedge clk);
    chk("R10 after two edges", req, 64'h0000_0000_0000_0100);
    set_raw_settle('0);
    chk("R8 any clear", {63'd0, any}, 64'd0);

    // R3 mask-all with other data bits zero
    set_raw_settle('1);
    wr(5'h0C, 32'h0000_0001); model_mask(1'b0, 32'h1);
    rd(5'h08, d); chk("R3 mask hi all", {32'd0, d}, 64'hFFFF_FFFF);
    rd(5'h0C, d); chk("R3 mask lo all, bit0 reads 0", {32'd0, d}, 64'hFFFF_FFFE);
    chk("R3 req blocked", req, 64'd0);

    // R4 selective unmask after mask-all
    wr(5'h08, 32'hFFFF_FFEF); model_mask(1'b1, 32'hFFFF_FFEF);
    wr(5'h0C, 32'hFFFF_FFF6); model_mask(1'b0, 32'hFFFF_FFF6);
    @(negedge clk);
    chk("R4 selective unmask", req, 64'h0000_0010_0000_0008);

    // R5 force bypasses mask, R7 force bit 0
    wr(5'h0C, 32'h1); model_mask(1'b0, 32'h1);
    wr(5'h14, 32'h0000_0001); wr(5'h10, 32'h8000_0000);
    @(negedge clk);
    chk("R5 R7 force under mask", req, 64'h8000_0000_0000_0001);
    chk("R8 any by force", {63'd0, any}, 64'd1);
    rd(5'h14, d); chk("R5 force lo readback", {32'd0, d}, 64'd1);
    wr(5'h14, 32'h0); wr(5'h10, 32'h0);
    @(negedge clk);
    chk("R5 force withdrawn", req, 64'd0);

    // R9 pending writes inert, unmapped and misaligned reads zero
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
    rd(5'h08, d); chk("R9 mask hi after pend write", {32'd0, d}, 64'hFFFF_FFFF);
    rd(5'h14, d); chk("R9 force lo after pend write", {32'd0, d}, 64'd0);
    rd(5'h04, d); chk("R9 pend lo unchanged", {32'd0, d}, 64'hFFFF_FFFE);
    rd(5'h18, d); chk("R9 unmapped 0x18", {32'd0, d}, 64'd0);
    rd(5'h1C, d); chk("R9 unmapped 0x1C", {32'd0, d}, 64'd0);
    rd(5'h0A, d); chk("R9 misaligned 0x0A", {32'd0, d}, 64'd0);
    m_force = '0;

    // random mix of mask, force and raw
    for (int it = 0; it < 200; it++) begin
      logic [31:0] mh, ml, fh, fl;
      logic [63:0] rv, e;
      mh = $urandom; ml = $urandom;
      ml[0] = (($urandom % 8) == 0);
      fh = $urandom & $urandom & $urandom;
      fl = $urandom & $urandom & $urandom;
      rv = {$urandom, $urandom};
      wr(5'h08, mh); model_mask(1'b1, mh);
      wr(5'h0C, ml); model_mask(1'b0, ml);
      wr(5'h10, fh); wr(5'h14, fl);
      m_force = {fh, fl};
      set_raw_settle(rv);
      e = exp_req(rv, m_mask, m_force);
      chk("R2 R5 R7 random req", req, e);
      chk("R8 random any", {63'd0, any}, {63'd0, (e != 0)});
      rd(5'h04, d); chk("R6 random pend lo", {32'd0, d}, {32'd0, rv[31:1], 1'b0});
      rd(5'h00, d); chk("R6 random pend hi", {32'd0, d}, {32'd0, rv[63:32]});
      rd(5'h0C, d); chk("R3 R4 random mask lo", {32'd0, d}, {32'd0, m_mask[31:0]});
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule